// File: doc/BRIEF.md
# Seconds Counter Real-Time Clock with Alarm

This block keeps wall-clock time as a plain 32-bit count of seconds. A one-second strobe from an external prescaler advances the count while the run bit is set. Software talks to it through a byte-wide synchronous register bus (address, write data, write strobe, read strobe, read data). The count is exposed byte by byte, least significant byte at the lowest address. Calendar conversion is left to software.

A new time is loaded in stages. Writes to the upper write-data bytes only park data. A write to write-byte 0 moves all staged bytes, plus the byte being written, into the counter in a single cycle. Software first writes zero to write-byte 0 so the low byte cannot carry into the upper bytes while those are being written, then writes bytes 1 to 3, and finally writes the real low byte. The read bytes show the live count with no snapshot. A multi-byte read can therefore tear when a tick lands between byte reads. Software detects the tear by re-reading byte 0 and repeating the read if that byte went down.

A 32-bit alarm value is compared with the count on every tick. When the alarm is enabled and they match, a sticky pending state drives the interrupt line high. Software treats the line as rising-edge triggered. It stays high until software writes the clear bit. The pending state is held in a two-state machine: `AL_IDLE` moves to `AL_PENDING` on an enabled tick match (transition *hit*). `AL_PENDING` returns to `AL_IDLE` on a clear write made in a cycle with no new hit (transition *clear*). Every other case holds the current state.

Top module: `sec_rtc`

Register offsets: 0 run control, 1 alarm control, 2..5 write-data bytes 0..3, 6..9 live-count bytes 0..3, 0x0A..0x0D alarm-value bytes 0..3, 0x0E alarm clear.

## Requirements
- R1: After reset the count, the alarm value, the run bit, the alarm enable and the pending state are all zero, the interrupt is low, and every register reads 0.
- R2: Bit 7 of offset 0 is the run bit. With it set, each cycle with `tick_i` high adds one to the count. With it clear, the count holds.
- R3: A counting tick at 0xFFFFFFFF wraps the count to 0x00000000.
- R4: Writes to offsets 3, 4 and 5 (write-bytes 1..3) only stage data and leave the count unchanged. Write-byte offsets read back as 0.
- R5: A write to offset 2 loads the count, in the following cycle, with {staged byte 3, staged byte 2, staged byte 1, written data}. A load takes priority over a tick in the same cycle.
- R6: Offsets 6..9 return count bytes 0..3 (little-endian) from the live count in the same cycle as the read strobe, with no snapshot. A tick between byte reads is therefore visible, and the byte-0 re-read shows it.
- R7: Offsets 0x0A..0x0D hold alarm-value bytes 0..3 (little-endian) and read back what was written.
- R8: Bit 1 of offset 1 is the alarm enable. A cycle with `tick_i` high, the enable set and the count equal to the alarm value makes `alarm_irq_o` high from the next cycle. With the enable clear, no match raises it.
- R9: The pending state is sticky: it stays high through later ticks and through clearing the alarm enable.
- R10: Writing 1 to bit 0 of offset 0x0E clears the pending state from the next cycle. Writing 0 there has no effect. If a new hit occurs in the same cycle, the hit wins and the line stays high.
- R11: Offset 0 reads back only the run bit at bit 7, and offset 1 reads back only the enable at bit 1. All other bits of both read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_i | input | 1 | One-second strobe, one cycle wide |
| bus_addr | input | ADDR_W (4) | Register offset |
| bus_wdata | input | 8 | Write data byte |
| bus_we | input | 1 | Write strobe |
| bus_re | input | 1 | Read strobe; read data is valid in the same cycle |
| bus_rdata | output | 8 | Read data byte, 0 when not reading |
| alarm_irq_o | output | 1 | Alarm interrupt level, high while the alarm is pending |

## Verification
The counter is exercised with ticks while stopped and while running, and with a load at the all-ones boundary followed by a tick, so that holding, incrementing and wrapping can be told apart. The staged load is checked by reading the count after each partial write (staging only) and after the byte-0 commit (byte order), and by a load coinciding with a tick (priority). A read sequence with a tick placed between byte 0 and byte 1 at a 0xFF low byte shows the tear that the re-read must catch. The alarm is driven through the matching count with the enable off and then on, and is then cleared by disabling, by a zero clear write, by a real clear, and by a clear coinciding with a fresh hit. These cases separate edge detection, stickiness and the clear priority.

// File: rtl/sec_rtc_pkg.sv
package sec_rtc_pkg;

    localparam int BYTE_W      = 8;

    // register offsets
    localparam int OFS_CTRL    = 0;
    localparam int OFS_ALCTRL  = 1;
    localparam int OFS_WR0     = 2;
    localparam int OFS_RD0     = 6;
    localparam int OFS_ALV0    = 10;
    localparam int OFS_ALCLR   = 14;

    // bit positions
    localparam int RUN_BIT     = 7;
    localparam int AL_EN_BIT   = 1;
    localparam int AL_CLR_BIT  = 0;

    typedef enum logic {
        AL_IDLE    = 1'b0,
        AL_PENDING = 1'b1
    } alarm_state_e;

endpackage

// File: rtl/sec_rtc_regs.sv
module sec_rtc_regs
    import sec_rtc_pkg::*;
#(
    parameter int ADDR_W = 4,
    parameter int NBYTES = 4
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [ADDR_W-1:0]        bus_addr,
    input  logic [BYTE_W-1:0]        bus_wdata,
    input  logic                     bus_we,
    input  logic                     bus_re,
    input  logic [BYTE_W*NBYTES-1:0] cnt_q,
    output logic [BYTE_W-1:0]        bus_rdata,
    output logic                     run_en,
    output logic                     alarm_en,
    output logic [BYTE_W*NBYTES-1:0] alarm_val,
    output logic                     load_pulse,
    output logic [BYTE_W*NBYTES-1:0] load_val,
    output logic                     clr_pulse
);

    localparam int CW = BYTE_W * NBYTES;

    logic [BYTE_W-1:0] stage_q [1:NBYTES-1];
    logic [BYTE_W-1:0] alarm_b [0:NBYTES-1];

    logic wr_ctrl;
    logic wr_alctrl;

    assign wr_ctrl    = bus_we && (bus_addr == ADDR_W'(OFS_CTRL));
    assign wr_alctrl  = bus_we && (bus_addr == ADDR_W'(OFS_ALCTRL));
    assign load_pulse = bus_we && (bus_addr == ADDR_W'(OFS_WR0));
    assign clr_pulse  = bus_we && (bus_addr == ADDR_W'(OFS_ALCLR))
                        && bus_wdata[AL_CLR_BIT];

    // control bits
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run_en   <= 1'b0;
            alarm_en <= 1'b0;
        end else begin
            if (wr_ctrl)   run_en   <= bus_wdata[RUN_BIT];
            if (wr_alctrl) alarm_en <= bus_wdata[AL_EN_BIT];
        end
    end

    // staging bytes for the upper part of a new count
    for (genvar i = 1; i < NBYTES; i++) begin : g_stage
        always_ff @(posedge clk) begin
            if (!rst_n)
                stage_q[i] <= '0;
            else if (bus_we && (bus_addr == ADDR_W'(OFS_WR0 + i)))
                stage_q[i] <= bus_wdata;
        end
    end

    // alarm value bytes
    for (genvar i = 0; i < NBYTES; i++) begin : g_alarm
        always_ff @(posedge clk) begin
            if (!rst_n)
                alarm_b[i] <= '0;
            else if (bus_we && (bus_addr == ADDR_W'(OFS_ALV0 + i)))
                alarm_b[i] <= bus_wdata;
        end
    end

    // assemble wide values
    always_comb begin
        load_val = '0;
        load_val[BYTE_W-1:0] = bus_wdata;
        for (int i = 1; i < NBYTES; i++)
            load_val[BYTE_W*i +: BYTE_W] = stage_q[i];
    end

    always_comb begin
        alarm_val = '0;
        for (int i = 0; i < NBYTES; i++)
            alarm_val[BYTE_W*i +: BYTE_W] = alarm_b[i];
    end

    // read mux: live values, no snapshot
    always_comb begin
        bus_rdata = '0;
        if (bus_re) begin
            if (bus_addr == ADDR_W'(OFS_CTRL))
                bus_rdata[RUN_BIT] = run_en;
            if (bus_addr == ADDR_W'(OFS_ALCTRL))
                bus_rdata[AL_EN_BIT] = alarm_en;
            for (int i = 0; i < NBYTES; i++) begin
                if (bus_addr == ADDR_W'(OFS_RD0 + i))
                    bus_rdata = cnt_q[BYTE_W*i +: BYTE_W];
                if (bus_addr == ADDR_W'(OFS_ALV0 + i))
                    bus_rdata = alarm_b[i];
            end
        end
    end

    logic unused_cw;
    assign unused_cw = (CW == 0);

endmodule

// File: rtl/sec_rtc_counter.sv
module sec_rtc_counter #(
    parameter int CW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tick_i,
    input  logic          run_en,
    input  logic          load_pulse,
    input  logic [CW-1:0] load_val,
    output logic [CW-1:0] cnt_q
);

    // a load wins over a tick in the same cycle
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (load_pulse)
            cnt_q <= load_val;
        else if (tick_i && run_en)
            cnt_q <= cnt_q + CW'(1);
    end

endmodule

// File: rtl/sec_rtc_alarm.sv
module sec_rtc_alarm
    import sec_rtc_pkg::*;
#(
    parameter int CW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tick_i,
    input  logic          alarm_en,
    input  logic [CW-1:0] cnt_q,
    input  logic [CW-1:0] alarm_val,
    input  logic          clr_pulse,
    output logic          irq_o
);

    alarm_state_e state_q, state_d;
    logic         hit;

    assign hit = tick_i && alarm_en && (cnt_q == alarm_val);

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n)
            state_q <= AL_IDLE;
        else
            state_q <= state_d;
    end

    // transitions: hit sets, clear releases unless a new hit arrives
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            AL_IDLE:    if (hit)                    state_d = AL_PENDING;
            AL_PENDING: if (clr_pulse && !hit)      state_d = AL_IDLE;
            default:                                state_d = AL_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        irq_o = 1'b0;
        unique case (state_q)
            AL_IDLE:    irq_o = 1'b0;
            AL_PENDING: irq_o = 1'b1;
            default:    irq_o = 1'b0;
        endcase
    end

endmodule

// File: rtl/sec_rtc.sv
module sec_rtc
    import sec_rtc_pkg::*;
#(
    parameter int ADDR_W = 4,
    parameter int NBYTES = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_i,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [7:0]        bus_wdata,
    input  logic              bus_we,
    input  logic              bus_re,
    output logic [7:0]        bus_rdata,
    output logic              alarm_irq_o
);

    localparam int CW = BYTE_W * NBYTES;

    logic [CW-1:0] cnt_q;
    logic [CW-1:0] alarm_val;
    logic [CW-1:0] load_val;
    logic          run_en;
    logic          alarm_en;
    logic          load_pulse;
    logic          clr_pulse;

    sec_rtc_regs #(.ADDR_W(ADDR_W), .NBYTES(NBYTES)) regs_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .bus_addr   (bus_addr),
        .bus_wdata  (bus_wdata),
        .bus_we     (bus_we),
        .bus_re     (bus_re),
        .cnt_q      (cnt_q),
        .bus_rdata  (bus_rdata),
        .run_en     (run_en),
        .alarm_en   (alarm_en),
        .alarm_val  (alarm_val),
        .load_pulse (load_pulse),
        .load_val   (load_val),
        .clr_pulse  (clr_pulse)
    );

    sec_rtc_counter #(.CW(CW)) cnt_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .tick_i     (tick_i),
        .run_en     (run_en),
        .load_pulse (load_pulse),
        .load_val   (load_val),
        .cnt_q      (cnt_q)
    );

    sec_rtc_alarm #(.CW(CW)) alarm_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .tick_i     (tick_i),
        .alarm_en   (alarm_en),
        .cnt_q      (cnt_q),
        .alarm_val  (alarm_val),
        .clr_pulse  (clr_pulse),
        .irq_o      (alarm_irq_o)
    );

endmodule

// File: rtl/sec_rtc_sva.sv
module sec_rtc_sva
    import sec_rtc_pkg::*;
#(
    parameter int ADDR_W = 4,
    parameter int CW     = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              tick_i,
    input logic [ADDR_W-1:0] bus_addr,
    input logic              bus_we,
    input logic              clr_bit,
    input logic              run_en,
    input logic              alarm_en,
    input logic [CW-1:0]     cnt_q,
    input logic [CW-1:0]     alarm_val,
    input logic [CW-1:0]     load_val,
    input logic              alarm_irq_o
);

    localparam int NB = CW / BYTE_W;

    logic do_load, do_clear, stage_wr, do_hit;
    assign do_load  = bus_we && (bus_addr == ADDR_W'(OFS_WR0));
    assign do_clear = bus_we && (bus_addr == ADDR_W'(OFS_ALCLR)) && clr_bit;
    assign stage_wr = bus_we && (bus_addr >= ADDR_W'(OFS_WR0 + 1))
                      && (bus_addr <= ADDR_W'(OFS_WR0 + NB - 1));
    assign do_hit   = tick_i && alarm_en && (cnt_q == alarm_val);

    AST_RUN_INCR: assert property (@(posedge clk) disable iff (!rst_n)
        (run_en && tick_i && !do_load) |=> (cnt_q == $past(cnt_q) + CW'(1))); // R2
    AST_HOLD_STOPPED: assert property (@(posedge clk) disable iff (!rst_n)
        (!run_en && !do_load) |=> $stable(cnt_q)); // R2
    AST_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        (run_en && tick_i && !do_load && (cnt_q == '1)) |=> (cnt_q == '0)); // R3
    AST_STAGE_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
        (stage_wr && !run_en) |=> $stable(cnt_q)); // R4
    AST_COMMIT: assert property (@(posedge clk) disable iff (!rst_n)
        do_load |=> (cnt_q == $past(load_val))); // R5
    AST_NO_SET_DISABLED: assert property (@(posedge clk) disable iff (!rst_n)
        (!alarm_irq_o && !alarm_en) |=> !alarm_irq_o); // R8
    AST_HIT_SETS: assert property (@(posedge clk) disable iff (!rst_n)
        do_hit |=> alarm_irq_o); // R8
    AST_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (alarm_irq_o && !do_clear) |=> alarm_irq_o); // R9
    AST_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        (do_clear && !do_hit) |=> !alarm_irq_o); // R10

endmodule

bind sec_rtc sec_rtc_sva #(.ADDR_W(ADDR_W), .CW(CW)) sva_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .tick_i      (tick_i),
    .bus_addr    (bus_addr),
    .bus_we      (bus_we),
    .clr_bit     (bus_wdata[0]),
    .run_en      (run_en),
    .alarm_en    (alarm_en),
    .cnt_q       (cnt_q),
    .alarm_val   (alarm_val),
    .load_val    (load_val),
    .alarm_irq_o (alarm_irq_o)
);

// File: tb/sec_rtc_tb_top.sv
module sec_rtc_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 20000;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick_i = 1'b0;
    logic [3:0] bus_addr = '0;
    logic [7:0] bus_wdata = '0;
    logic       bus_we = 1'b0;
    logic       bus_re = 1'b0;
    logic [7:0] bus_rdata;
    logic       alarm_irq_o;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    sec_rtc dut_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .tick_i      (tick_i),
        .bus_addr    (bus_addr),
        .bus_wdata   (bus_wdata),
        .bus_we      (bus_we),
        .bus_re      (bus_re),
        .bus_rdata   (bus_rdata),
        .alarm_irq_o (alarm_irq_o)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a, output logic [7:0] d);
        @(negedge clk);
        bus_re = 1'b1; bus_addr = a;
        #1 d = bus_rdata;
        bus_re = 1'b0;
    endtask

    task automatic rd_count(output logic [31:0] v);
        logic [7:0] b;
        for (int i = 0; i < 4; i++) begin
            rd(4'(6 + i), b);
            v[8*i +: 8] = b;
        end
    endtask

    task automatic pulse_tick(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            tick_i = 1'b1;
            @(negedge clk);
            tick_i = 1'b0;
        end
    endtask

    task automatic set_count(input logic [31:0] v);
        wr(4'd2, 8'h00);
        wr(4'd3, v[15:8]);
        wr(4'd4, v[23:16]);
        wr(4'd5, v[31:24]);
        wr(4'd2, v[7:0]);
    endtask

    task automatic t_reset();
        logic [7:0]  b;
        logic [31:0] v;
        rd_count(v);       check("R1 count", v, 32'h0);
        rd(4'd0, b);       check("R1 ctrl", {24'h0, b}, 32'h0);
        rd(4'd1, b);       check("R1 alarm ctrl", {24'h0, b}, 32'h0);
        for (int i = 0; i < 4; i++) begin
            rd(4'(10 + i), b); check("R1 alarm byte", {24'h0, b}, 32'h0);
        end
        check("R1 irq", {31'h0, alarm_irq_o}, 32'h0);
    endtask

    task automatic t_staged();
        logic [31:0] v;
        logic [7:0]  b;
        wr(4'd2, 8'h00);
        wr(4'd3, 8'h12);
        wr(4'd4, 8'h34);
        wr(4'd5, 8'h56);
        rd_count(v);   check("R4 staging leaves count", v, 32'h0);
        rd(4'd4, b);   check("R4 write byte reads 0", {24'h0, b}, 32'h0);
        wr(4'd2, 8'h78);
        rd_count(v);   check("R5 commit order", v, 32'h56341278);
    endtask

    task automatic t_run();
        logic [31:0] v;
        logic [7:0]  b;
        pulse_tick(2);
        rd_count(v);   check("R2 hold when stopped", v, 32'h56341278);
        wr(4'd0, 8'hFF);
        rd(4'd0, b);   check("R11 ctrl readback", {24'h0, b}, 32'h80);
        pulse_tick(3);
        rd_count(v);   check("R2 counting", v, 32'h5634127B);
    endtask

    task automatic t_wrap();
        logic [31:0] v;
        set_count(32'hFFFFFFFF);
        rd_count(v);   check("R5 load all ones", v, 32'hFFFFFFFF);
        pulse_tick(1);
        rd_count(v);   check("R3 wrap", v, 32'h0);
    endtask

    task automatic t_load_prio();
        logic [31:0] v;
        @(negedge clk);
        tick_i = 1'b1; bus_we = 1'b1; bus_addr = 4'd2; bus_wdata = 8'h10;
        @(negedge clk);
        tick_i = 1'b0; bus_we = 1'b0;
        rd_count(v);   check("R5 load beats tick", v, 32'hFFFFFF10);
    endtask

    task automatic t_tear();
        logic [7:0]  b0, b0_again, b;
        logic [31:0] v;
        set_count(32'h000000FF);
        rd(4'd6, b0);          check("R6 first low byte", {24'h0, b0}, 32'hFF);
        pulse_tick(1);
        rd(4'd7, b);           check("R6 live byte 1 after tick", {24'h0, b}, 32'h01);
        rd(4'd6, b0_again);
        check("R6 tear visible on re-read", {31'h0, (b0_again < b0)}, 32'h1);
        rd_count(v);           check("R6 repeated read", v, 32'h00000100);
    endtask

    task automatic t_alarm();
        logic [7:0]  b;
        logic [31:0] v;
        wr(4'd10, 8'h05); wr(4'd11, 8'h01); wr(4'd12, 8'h00); wr(4'd13, 8'h00);
        rd(4'd10, b);  check("R7 alarm byte 0", {24'h0, b}, 32'h05);
        rd(4'd11, b);  check("R7 alarm byte 1", {24'h0, b}, 32'h01);
        set_count(32'h100);
        pulse_tick(6);
        rd_count(v);   check("R8 passed match", v, 32'h106);
        check("R8 disabled no irq", {31'h0, alarm_irq_o}, 32'h0);
        set_count(32'h100);
        wr(4'd1, 8'hFF);
        rd(4'd1, b);   check("R11 alarm ctrl readback", {24'h0, b}, 32'h02);
        pulse_tick(5);
        check("R8 no irq before match", {31'h0, alarm_irq_o}, 32'h0);
        pulse_tick(1);
        check("R8 irq on match", {31'h0, alarm_irq_o}, 32'h1);
        pulse_tick(2);
        check("R9 sticky over ticks", {31'h0, alarm_irq_o}, 32'h1);
        wr(4'd1, 8'h00);
        check("R9 disable keeps pending", {31'h0, alarm_irq_o}, 32'h1);
        wr(4'd14, 8'hFE);
        check("R10 zero clear ignored", {31'h0, alarm_irq_o}, 32'h1);
        wr(4'd14, 8'h01);
        check("R10 clear", {31'h0, alarm_irq_o}, 32'h0);
    endtask

    task automatic t_setwins();
        wr(4'd0, 8'h00);
        set_count(32'h105);
        wr(4'd1, 8'h02);
        @(negedge clk);
        tick_i = 1'b1; bus_we = 1'b1; bus_addr = 4'd14; bus_wdata = 8'h01;
        @(negedge clk);
        tick_i = 1'b0; bus_we = 1'b0;
        check("R10 hit wins over clear", {31'h0, alarm_irq_o}, 32'h1);
        wr(4'd14, 8'h01);
        check("R10 clear after hit", {31'h0, alarm_irq_o}, 32'h0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_staged();
        t_run();
        t_wrap();
        t_load_prio();
        t_tear();
        t_alarm();
        t_setwins();
        if (!done) begin
            done = 1'b1;
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_chk++;
            n_fail++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

endmodule